// File: doc/BRIEF.md
# Audio Serial Framer

This block is the bit-level engine of a buffered audio serial port. It turns parallel sample words into a serial stream on one data pin and turns a second serial pin back into parallel words. Both directions are aligned to a frame sync. It is a sync follower: the bit clock and frame sync come from outside and are sampled in the system clock domain. Toward the core it exposes a single word handshake per direction. The transmit side consumes one word at the start of each slot. The receive side pulses a valid strobe with the channel number when each word completes.

One engine covers four serial formats. The format selects the data delay after the sync edge, the active sync level and the frame layout. A two-channel stream in an I2S-style or left-justified format uses a two-phase frame: phase 1 starts on the active sync edge and carries channel 0, phase 2 starts on the opposite edge and carries channel 1. All other cases use one phase that carries every channel back to back. Word length is 16 or 32 bits and applies to every slot in both directions.

Top module: `audio_frame_serdes`

## Requirements
- R1: While reset is asserted and after its release, `sdout`, `tx_ready`, `tx_urun`, `rx_valid` and `sync_err` are 0 and `rx_data` and `rx_ch` are 0.
- R2: `cfg_wide`=1 selects 32-bit words and `cfg_wide`=0 selects 16-bit words. A 16-bit slot sends `tx_data[15:0]`, and a received 16-bit word appears zero-extended in `rx_data[15:0]`.
- R3: Words are sent MSB first. Receive data and frame sync are sampled on the rising logical bit-clock edge. The transmit bit is updated on the falling edge that follows the rising edge at which its slot position is reached. Outside a slot, `sdout` is 0.
- R4: `cfg_fmt` encodes 0 = I2S-style, 1 = left-justified, 2 = DSP with one-bit delay, 3 = DSP with zero delay. Formats 0 and 2 place bit 0 of a phase one bit clock after the rising edge that detects the sync edge. Formats 1 and 3 place it on that same edge.
- R5: The active sync level is 0 for format 0 and 1 for formats 1 to 3. `cfg_sync_inv`=1 inverts it. A phase starts when the sampled sync changes to the active level.
- R6: When `cfg_chans_m1`=1 and the format is 0 or 1, the frame has two phases of one word each. The active-going sync edge starts channel 0 and the opposite edge starts channel 1.
- R7: In all other cases one phase carries `cfg_chans_m1`+1 words back to back, with `rx_ch` counting from 0. The opposite sync edge is ignored. Up to 16 channels are supported.
- R8: A phase start that arrives while bits of the current phase are still due aborts that phase, restarts at the new phase and pulses `sync_err` for one cycle. With a one-bit delay, a start detected on the rising edge that carries the last bit of the current phase is legal: that bit is still transferred.
- R9: If `tx_valid` is 0 when a slot starts, the slot sends zeros, `tx_urun` pulses for one cycle and no word is consumed.
- R10: `cfg_bclk_inv`=1 inverts the bit-clock pin, which swaps the sampling and launch edges.
- R11: `tx_ready` pulses for one cycle for each word taken, at most once per slot, and only when `tx_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wide | input | 1 | Word length select, 1 = 32 bits |
| cfg_fmt | input | 2 | Serial format code |
| cfg_chans_m1 | input | CHW | Channel count minus one |
| cfg_sync_inv | input | 1 | Invert frame sync polarity |
| cfg_bclk_inv | input | 1 | Invert bit clock polarity |
| bclk | input | 1 | Bit clock pin |
| fsync | input | 1 | Frame sync pin |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| tx_data | input | 32 | Word offered for transmission |
| tx_valid | input | 1 | `tx_data` holds a word |
| tx_ready | output | 1 | Word taken this cycle |
| tx_urun | output | 1 | Slot started without a word |
| rx_data | output | 32 | Last received word |
| rx_valid | output | 1 | `rx_data` updated |
| rx_ch | output | CHW | Channel of the received word |
| sync_err | output | 1 | Premature phase start |

## Verification
The assertions assume that the bit clock stays in each logical level for at least two system clock cycles, so that slot events are never in adjacent cycles. They also assume that bit clock, sync and data pins are synchronous to `clk`, and that configuration changes only while reset is asserted. The stimulus meets all three: it holds each bit-clock half for four cycles, drives every pin on the falling system clock edge, and applies reset around every change of format, polarity, word length or channel count.

// File: rtl/audio_frame_serdes.sv
module audio_frame_serdes #(
  parameter int MAX_CH = 16,
  localparam int CHW = $clog2(MAX_CH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wide,
  input  logic [1:0]     cfg_fmt,
  input  logic [CHW-1:0] cfg_chans_m1,
  input  logic           cfg_sync_inv,
  input  logic           cfg_bclk_inv,
  input  logic           bclk,
  input  logic           fsync,
  input  logic           sdin,
  output logic           sdout,
  input  logic [31:0]    tx_data,
  input  logic           tx_valid,
  output logic           tx_ready,
  output logic           tx_urun,
  output logic [31:0]    rx_data,
  output logic           rx_valid,
  output logic [CHW-1:0] rx_ch,
  output logic           sync_err
);

  localparam logic [1:0] FMT_I2S  = 2'd0;
  localparam logic [1:0] FMT_DSP1 = 2'd2;

  logic           bk_q, fs_q, primed, active, nbit;
  logic [4:0]     bcnt;
  logic [CHW-1:0] wleft, ch;
  logic [31:0]    sh, rsh;

  wire dly  = (cfg_fmt == FMT_I2S) || (cfg_fmt == FMT_DSP1);
  wire dual = (cfg_chans_m1 == CHW'(1)) && !cfg_fmt[1];
  wire act  = (cfg_fmt != FMT_I2S) ^ cfg_sync_inv;
  wire bk   = bclk ^ cfg_bclk_inv;
  wire rise = bk & ~bk_q;
  wire fall = ~bk & bk_q;

  wire start_a = rise & primed & (fsync == act) & (fs_q != act);
  wire start_b = rise & primed & dual & (fsync != act) & (fs_q == act);
  wire start   = start_a | start_b;
  wire last    = (bcnt == 5'd0) && (wleft == '0);

  wire new_bit = start & ~dly;
  wire old_bit = rise & active & ~new_bit;
  wire bit_ev  = new_bit | old_bit;

  wire [4:0]     f_bcnt  = cfg_wide ? 5'd31 : 5'd15;
  wire [CHW-1:0] f_wleft = dual ? '0 : cfg_chans_m1;
  wire [CHW-1:0] f_ch    = start_b ? CHW'(1) : '0;

  wire [4:0]     c_bcnt  = new_bit ? f_bcnt  : bcnt;
  wire [CHW-1:0] c_wleft = new_bit ? f_wleft : wleft;
  wire [CHW-1:0] c_ch    = new_bit ? f_ch    : ch;

  wire        first = c_bcnt == f_bcnt;
  wire        load  = bit_ev & first;
  wire [31:0] lw    = !tx_valid ? 32'h0 : (cfg_wide ? tx_data : {tx_data[15:0], 16'h0});
  wire [31:0] cur   = first ? lw : sh;
  wire [31:0] rnew  = {rsh[30:0], sdin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_q <= 1'b0; fs_q <= 1'b0; primed <= 1'b0; active <= 1'b0; nbit <= 1'b0;
      bcnt <= '0; wleft <= '0; ch <= '0; sh <= '0; rsh <= '0;
      sdout <= 1'b0; tx_ready <= 1'b0; tx_urun <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; rx_ch <= '0; sync_err <= 1'b0;
    end else begin
      bk_q     <= bk;
      tx_ready <= load & tx_valid;
      tx_urun  <= load & ~tx_valid;
      rx_valid <= 1'b0;
      sync_err <= 1'b0;
      if (fall) sdout <= nbit;
      if (rise) begin
        fs_q     <= fsync;
        primed   <= 1'b1;
        sync_err <= start & active & ~(dly & last);
        nbit     <= bit_ev ? cur[31] : 1'b0;
      end
      if (bit_ev) begin
        sh  <= cur << 1;
        rsh <= rnew;
        if (c_bcnt == 5'd0) begin
          rx_valid <= 1'b1;
          rx_data  <= cfg_wide ? rnew : {16'h0, rnew[15:0]};
          rx_ch    <= c_ch;
        end
      end
      if (start & dly) begin
        active <= 1'b1;
        bcnt   <= f_bcnt;
        wleft  <= f_wleft;
        ch     <= f_ch;
      end else if (bit_ev) begin
        if (c_bcnt != 5'd0) begin
          active <= 1'b1;
          bcnt   <= c_bcnt - 5'd1;
          wleft  <= c_wleft;
          ch     <= c_ch;
        end else if (c_wleft != '0) begin
          active <= 1'b1;
          bcnt   <= f_bcnt;
          wleft  <= c_wleft - CHW'(1);
          ch     <= c_ch + CHW'(1);
        end else begin
          active <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/audio_frame_serdes_chk.sv
module audio_frame_serdes_chk #(
  parameter int CHW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_wide,
  input logic [CHW-1:0] cfg_chans_m1,
  input logic           cfg_bclk_inv,
  input logic           bclk,
  input logic           sdout,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic           tx_urun,
  input logic [31:0]    rx_data,
  input logic           rx_valid,
  input logic [CHW-1:0] rx_ch,
  input logic           sync_err
);

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  a_r11_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> $past(tx_valid));

  a_r9_take_or_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && tx_urun));

  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);

  a_r2_narrow_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_wide) |-> (rx_data[31:16] == 16'h0));

  a_r7_channel_range: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_ch <= cfg_chans_m1));

  a_r3_launch_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(!(bclk ^ cfg_bclk_inv)));

endmodule

bind audio_frame_serdes audio_frame_serdes_chk #(.CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_chans_m1(cfg_chans_m1),
  .cfg_bclk_inv(cfg_bclk_inv), .bclk(bclk), .sdout(sdout), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_urun(tx_urun), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ch(rx_ch), .sync_err(sync_err)
);

// File: tb/test_audio_frame_serdes.sv
module test_audio_frame_serdes;
  localparam int CHW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_wide = 1'b0, cfg_sync_inv = 1'b0, cfg_bclk_inv = 1'b0;
  logic [1:0] cfg_fmt = 2'd0;
  logic [CHW-1:0] cfg_chans_m1 = '0;
  logic bclk = 1'b0, fsync = 1'b1, sdin = 1'b0, tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic sdout, tx_ready, tx_urun, rx_valid, sync_err;
  logic [31:0] rx_data;
  logic [CHW-1:0] rx_ch;

  audio_frame_serdes i_audio_frame_serdes (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_fmt(cfg_fmt),
    .cfg_chans_m1(cfg_chans_m1), .cfg_sync_inv(cfg_sync_inv), .cfg_bclk_inv(cfg_bclk_inv),
    .bclk(bclk), .fsync(fsync), .sdin(sdin), .sdout(sdout),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_urun(tx_urun),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ch(rx_ch), .sync_err(sync_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0, running = 1'b0;
  string tag = "R1";
  logic [31:0] txq[$];

  // behavioural reference
  bit pl = 0, pfs = 0, primed = 0;
  int m_pos = -1, m_len = 0, m_base = 0;
  logic [31:0] m_word = '0, m_acc = '0;
  logic e_dout = 0, e_nb = 0, e_ready = 0, e_urun = 0, e_rv = 0, e_err = 0;
  logic [31:0] e_rx = '0;
  int e_ch = 0;

  function automatic int wlen();
    return cfg_wide ? 32 : 16;
  endfunction
  function automatic bit act_lvl();
    return (cfg_fmt != 2'd0) ^ cfg_sync_inv;
  endfunction
  function automatic bit delayed();
    return cfg_fmt == 2'd0 || cfg_fmt == 2'd2;
  endfunction
  function automatic bit two_phase();
    return cfg_chans_m1 == 1 && cfg_fmt < 2'd2;
  endfunction

  task automatic model_bit();
    int w, k;
    w = wlen();
    k = m_pos % w;
    if (k == 0) begin
      if (tx_valid) begin
        m_word = cfg_wide ? tx_data : {16'h0, tx_data[15:0]};
        e_ready = 1;
      end else begin
        m_word = '0;
        e_urun = 1;
      end
    end
    e_nb = m_word[w-1-k];
    m_acc = {m_acc[30:0], sdin};
    if (k == w - 1) begin
      e_rv = 1;
      e_rx = cfg_wide ? m_acc : {16'h0, m_acc[15:0]};
      e_ch = m_base + m_pos / w;
    end
    m_pos++;
    if (m_pos == m_len) m_pos = -1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pl = 0; pfs = 0; primed = 0; m_pos = -1; m_acc = '0; m_word = '0;
      e_dout = 0; e_nb = 0; e_ready = 0; e_urun = 0; e_rv = 0; e_err = 0; e_rx = '0; e_ch = 0;
    end else begin
      bit lv, rs, fl, sa, sb, st;
      e_ready = 0; e_urun = 0; e_rv = 0; e_err = 0;
      lv = bclk ^ cfg_bclk_inv;
      rs = lv && !pl;
      fl = !lv && pl;
      pl = lv;
      if (fl) e_dout = e_nb;
      if (rs) begin
        sa = primed && fsync == act_lvl() && pfs != act_lvl();
        sb = primed && two_phase() && fsync != act_lvl() && pfs == act_lvl();
        st = sa || sb;
        if (st && m_pos >= 0 && !(delayed() && m_pos == m_len - 1)) e_err = 1;
        e_nb = 0;
        if (m_pos >= 0 && !(st && !delayed())) model_bit();
        if (st) begin
          m_len = wlen() * (two_phase() ? 1 : int'(cfg_chans_m1) + 1);
          m_base = sb ? 1 : 0;
          m_pos = 0;
          if (!delayed()) model_bit();
        end
        pfs = fsync;
        primed = 1;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (running) begin
      chk("R3 sdout", 32'(sdout), 32'(e_dout));
      chk("R11 tx_ready", 32'(tx_ready), 32'(e_ready));
      chk("R9 tx_urun", 32'(tx_urun), 32'(e_urun));
      chk("R2 rx_valid", 32'(rx_valid), 32'(e_rv));
      chk("R2 rx_data", rx_data, e_rx);
      chk("R7 rx_ch", 32'(rx_ch), 32'(e_ch));
      chk("R8 sync_err", 32'(sync_err), 32'(e_err));
    end
  end

  initial forever begin
    @(negedge clk);
    if (tx_ready && txq.size() > 0) void'(txq.pop_front());
    tx_valid = txq.size() > 0;
    tx_data = tx_valid ? txq[0] : '0;
  end

  task automatic one_bit(input bit fs);
    @(negedge clk);
    bclk = cfg_bclk_inv;
    fsync = fs;
    sdin = 1'($urandom);
    repeat (4) @(negedge clk);
    bclk = ~cfg_bclk_inv;
    repeat (3) @(negedge clk);
  endtask

  task automatic scen(input string t, input bit wide, input logic [1:0] fmt, input int chm1,
                      input bit sinv, input bit binv, input int nwords, input int frames,
                      input int flen, input int hiw);
    bit a;
    tag = t;
    @(negedge clk);
    rst_n = 0;
    cfg_wide = wide; cfg_fmt = fmt; cfg_chans_m1 = CHW'(chm1);
    cfg_sync_inv = sinv; cfg_bclk_inv = binv;
    a = act_lvl();
    bclk = binv; fsync = ~a;
    txq.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < nwords; i++) txq.push_back($urandom);
    for (int i = 0; i < 4; i++) one_bit(~a);
    for (int f = 0; f < frames; f++)
      for (int i = 0; i < flen; i++) one_bit(i < hiw ? a : ~a);
    for (int i = 0; i < 40; i++) one_bit(~a);
  endtask

  initial begin
    running = 1;
    repeat (3) @(negedge clk);
    chk("R1 sdout", 32'(sdout), 0);
    chk("R1 tx_ready", 32'(tx_ready), 0);
    chk("R1 rx_valid", 32'(rx_valid), 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 sync_err", 32'(sync_err), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle sdout", 32'(sdout), 0);
    chk("R1 idle tx_urun", 32'(tx_urun), 0);

    scen("R6 R4 R5 i2s 32b stereo",     1, 2'd0, 1,  0, 0, 4,  2, 64, 32);
    scen("R6 R4 R5 lj 16b inv sync",     0, 2'd1, 1,  1, 0, 4,  2, 32, 16);
    scen("R7 R4 dsp1 16b 4ch",           0, 2'd2, 3,  0, 0, 8,  2, 68, 1);
    scen("R10 R4 dsp0 32b 3ch bclk inv", 1, 2'd3, 2,  0, 1, 6,  2, 100, 1);
    scen("R7 R5 i2s 16b 4ch single",     0, 2'd0, 3,  0, 0, 8,  2, 64, 32);
    scen("R8 early sync dsp0",           0, 2'd3, 1,  0, 0, 8,  3, 20, 1);
    scen("R8 early sync i2s dual",       0, 2'd0, 1,  0, 0, 8,  2, 24, 12);
    scen("R9 underrun dsp1 32b",         1, 2'd2, 0,  0, 0, 1,  3, 36, 1);
    scen("R7 16ch dsp0 16b",             0, 2'd3, 15, 0, 0, 16, 1, 260, 1);

    running = 0;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule